// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of level-sensitive interrupt request lines and a processor core. Each line has a fixed priority: line `i` runs at priority `i + 1`, and priority 0 stands for ordinary program execution. The controller finds the highest-priority line that is asserted and compares it with the priority of the code now running. It raises the core's interrupt request only when the pending priority is strictly greater. While the request is raised, the number of the winning line is presented as the vector, which software uses to index its table of handler entry points.

When the core acknowledges, the controller saves the running priority on an internal last-in-first-out stack and adopts the winner's priority. Handlers can therefore nest, but only under a strictly higher priority. A return strobe pops the stack and restores the priority of the interrupted context. The running priority is always visible as an output, in the way a status-word field would show it.

A return with nothing saved leaves priority 0 and sets a sticky error flag. No request is latched inside the block: a line counts as serviced once the handler clears it at its source.

Top module: `nest_irq_ctrl`

## Requirements
- R1: The vector output is the index of the highest-numbered asserted request line. Line `i` has priority `i + 1`.
- R2: `irq` is high exactly when at least one line is asserted and the winner's priority is strictly greater than `cur_prio`. An equal or lower priority keeps `irq` low.
- R3: A clock edge with `ack` high and `irq` high (and `ret` low) sets `cur_prio` to the winner's priority on the next cycle. The previous value is saved on the stack.
- R4: `ack` while `irq` is low has no effect: `cur_prio` and the stack are unchanged.
- R5: A clock edge with `ret` high restores the priority that was saved by the matching acknowledge, in last-in-first-out order.
- R6: `ret` with an empty stack leaves `cur_prio` at 0 and sets `stack_err`. `stack_err` stays high until reset.
- R7: When `ret` and `ack` are both high in one cycle, the return is performed and the acknowledge is ignored.
- R8: After reset, `cur_prio` is 0, `stack_err` is 0 and the stack is empty, so any asserted line raises `irq`.
- R9: Eight nested acknowledges, each at a strictly higher priority, are all saved. Eight returns then unwind them in reverse order without raising `stack_err`.
- R10: Requests are level-sensitive. A line dropped before it is acknowledged no longer produces `irq` or a vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_lines | input | 8 | Level-sensitive interrupt request lines |
| ack | input | 1 | Acknowledge from the core |
| ret | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Interrupt request to the core |
| vector | output | 3 | Index of the winning line |
| cur_prio | output | 4 | Priority of the code now running |
| stack_err | output | 1 | Sticky flag for a return with nothing saved |

## Verification
The hardest state to reach is a full stack, where all eight priorities are nested. Reaching it takes a chain of acknowledges in which each one is strictly higher than the last, because any other order is refused at the comparison. The directed test raises lines 0 through 7 one at a time, acknowledging each, and checks the priority after every step. It then unwinds with eight returns and checks each restored level in reverse order. Only after that does it issue the one extra return that must set the error flag.

// File: rtl/nest_irq_pkg.sv
// Package: shared constants and the stack operation code for the
// nested interrupt controller. Assumes nothing beyond IEEE 1800-2017.
package nest_irq_pkg;

    localparam int unsigned LINES_DEFAULT = 8;
    localparam int unsigned DEPTH_DEFAULT = 8;

    // Operation requested from the priority stack in one cycle
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

endpackage

// File: rtl/nest_irq_winner.sv
// Module: picks the highest-numbered asserted request line and turns it
// into a vector and a priority (index + 1, or 0 when nothing is asserted).
// Assumes: purely combinational, request lines already synchronous.
module nest_irq_winner #(
    parameter int unsigned LINES = 8,
    parameter int unsigned IW    = $clog2(LINES),
    parameter int unsigned PW    = $clog2(LINES + 1)
) (
    input  logic [LINES-1:0] req,
    output logic             any,
    output logic [IW-1:0]    idx,
    output logic [PW-1:0]    prio
);

    // Per-line priority constants, one per request line
    logic [PW-1:0] line_prio [LINES];

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_prio
            assign line_prio[g] = PW'(g + 1);
        end
    endgenerate

    // Scan upward so the highest asserted line is the last to win
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        prio = '0;
        for (int i = 0; i < LINES; i++) begin
            if (req[i]) begin
                any  = 1'b1;
                idx  = IW'(i);
                prio = line_prio[i];
            end
        end
    end

    // R1: the selected line is asserted and no higher line is asserted
    always_comb begin
        if (any) begin
            a_r1_winner_asserted : assert (req[idx]);
            a_r1_none_above : assert ((req >> idx) == {{(LINES-1){1'b0}}, 1'b1});
        end
    end

endmodule

// File: rtl/nest_irq_stack.sv
// Module: last-in-first-out store of preempted priorities.
// Assumes: at most one operation per cycle; a push when full and a pop
// when empty are dropped (the caller flags them).
module nest_irq_stack
    import nest_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PW    = 4,
    parameter int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] top,
    output logic          empty,
    output logic          full
);

    logic [PW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] top_idx;

    // Decode occupancy and the addresses of the next free and top slots
    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == CW'(DEPTH));
        wr_idx  = AW'(cnt);
        top_idx = AW'(cnt - CW'(1));
        top     = empty ? '0 : mem[top_idx];
    end

    // Track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case (op)
                STK_PUSH: if (!full)  cnt <= cnt + CW'(1);
                STK_POP:  if (!empty) cnt <= cnt - CW'(1);
                default:  cnt <= cnt;
            endcase
        end
    end

    // Store pushed values; storage needs no reset
    always_ff @(posedge clk) begin
        if (op == STK_PUSH && !full) begin
            mem[wr_idx] <= din;
        end
    end

    // R9: occupancy never exceeds the depth
    a_r9_depth_bound : assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R5: a value pushed is what the top shows next cycle
    a_r5_push_visible : assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_PUSH && !full) |=> (top == $past(din)));

endmodule

// File: rtl/nest_irq_seq.sv
// Module: decides the interrupt request and the next running priority
// from the winner, the current priority and the core strobes.
// Assumes: return has precedence over acknowledge in the same cycle.
module nest_irq_seq
    import nest_irq_pkg::*;
#(
    parameter int unsigned PW = 4
) (
    input  logic          any,
    input  logic [PW-1:0] win_prio,
    input  logic [PW-1:0] cur_prio,
    input  logic          ack,
    input  logic          ret,
    input  logic          stk_empty,
    input  logic          stk_full,
    input  logic [PW-1:0] stk_top,
    output logic          irq,
    output stk_op_e       op,
    output logic [PW-1:0] nxt_prio,
    output logic          set_err
);

    // Request the core only for strictly higher pending priority
    always_comb begin
        irq = any && (win_prio > cur_prio);
    end

    // Choose the stack operation and the next running priority
    always_comb begin
        op       = STK_HOLD;
        nxt_prio = cur_prio;
        set_err  = 1'b0;
        if (ret) begin
            op       = STK_POP;
            nxt_prio = stk_empty ? '0 : stk_top;
            set_err  = stk_empty;
        end else if (ack && irq) begin
            op       = stk_full ? STK_HOLD : STK_PUSH;
            nxt_prio = win_prio;
            set_err  = stk_full;
        end
    end

endmodule

// File: rtl/nest_irq_ctrl.sv
// Module: top of the nested priority interrupt controller. Holds the
// running priority and the sticky error flag, and wires the winner
// selector, the sequencer and the priority stack together.
// Assumes: request lines are synchronous to clk; reset is synchronous,
// active low; irq and vector follow the request lines combinationally.
module nest_irq_ctrl
    import nest_irq_pkg::*;
#(
    parameter int unsigned LINES = LINES_DEFAULT,
    parameter int unsigned DEPTH = DEPTH_DEFAULT,
    parameter int unsigned IW    = $clog2(LINES),
    parameter int unsigned PW    = $clog2(LINES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_lines,
    input  logic             ack,
    input  logic             ret,
    output logic             irq,
    output logic [IW-1:0]    vector,
    output logic [PW-1:0]    cur_prio,
    output logic             stack_err
);

    logic          any;
    logic [PW-1:0] win_prio;
    logic [PW-1:0] nxt_prio;
    logic [PW-1:0] stk_top;
    logic          stk_empty;
    logic          stk_full;
    logic          set_err;
    stk_op_e       op;

    nest_irq_winner #(.LINES(LINES), .IW(IW), .PW(PW)) u_winner (
        .req  (req_lines),
        .any  (any),
        .idx  (vector),
        .prio (win_prio)
    );

    nest_irq_seq #(.PW(PW)) u_seq (
        .any       (any),
        .win_prio  (win_prio),
        .cur_prio  (cur_prio),
        .ack       (ack),
        .ret       (ret),
        .stk_empty (stk_empty),
        .stk_full  (stk_full),
        .stk_top   (stk_top),
        .irq       (irq),
        .op        (op),
        .nxt_prio  (nxt_prio),
        .set_err   (set_err)
    );

    nest_irq_stack #(.DEPTH(DEPTH), .PW(PW)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .din   (cur_prio),
        .top   (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    // Running priority register, status-word style
    always_ff @(posedge clk) begin
        if (!rst_n) cur_prio <= '0;
        else        cur_prio <= nxt_prio;
    end

    // Sticky error flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)       stack_err <= 1'b0;
        else if (set_err) stack_err <= 1'b1;
    end

    // R3: an accepted acknowledge moves to the vector's priority
    a_r3_ack_takes_vector : assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && !ret) |=> (cur_prio == PW'($past(vector)) + PW'(1)));

    // R4: acknowledge without a request leaves the priority alone
    a_r4_ack_idle_stable : assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq && !ret) |=> $stable(cur_prio));

    // R2: a raised request always outranks the running priority
    a_r2_irq_outranks : assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((PW'(vector) + PW'(1)) > cur_prio));

    // R5 / R7: a return never raises the running priority
    a_r5_ret_lowers : assert property (@(posedge clk) disable iff (!rst_n)
        ret |=> ((cur_prio < $past(cur_prio)) || ($past(cur_prio) == '0)));

    // R6: the error flag is sticky
    a_r6_err_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);

endmodule

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_lines;
    logic       ack;
    logic       ret;
    logic       irq;
    logic [2:0] vector;
    logic [3:0] cur_prio;
    logic       stack_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    nest_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_lines (req_lines),
        .ack       (ack),
        .ret       (ret),
        .irq       (irq),
        .vector    (vector),
        .cur_prio  (cur_prio),
        .stack_err (stack_err)
    );

    // Vector fields: req[18:11] ack[10] ret[9] irq[8] vec[7:5] prio_after[4:1] err_after[0]
    localparam int NV = 15;
    localparam logic [18:0] TBL [NV] = '{
        {8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b0}, // R2 idle
        {8'h04, 1'b0, 1'b0, 1'b1, 3'd2, 4'd0, 1'b0}, // R1 line 2 pending
        {8'h04, 1'b1, 1'b0, 1'b1, 3'd2, 4'd3, 1'b0}, // R3 ack -> 3
        {8'h04, 1'b0, 1'b0, 1'b0, 3'd0, 4'd3, 1'b0}, // R2 equal priority
        {8'h05, 1'b0, 1'b0, 1'b0, 3'd0, 4'd3, 1'b0}, // R2 lower priority
        {8'h01, 1'b1, 1'b0, 1'b0, 3'd0, 4'd3, 1'b0}, // R4 ack ignored
        {8'h24, 1'b0, 1'b0, 1'b1, 3'd5, 4'd3, 1'b0}, // R1 line 5 wins
        {8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 4'd3, 1'b0}, // R10 dropped line
        {8'h30, 1'b1, 1'b0, 1'b1, 3'd5, 4'd6, 1'b0}, // R3 nest -> 6
        {8'h80, 1'b1, 1'b1, 1'b1, 3'd7, 4'd3, 1'b0}, // R7 ret beats ack
        {8'h80, 1'b1, 1'b0, 1'b1, 3'd7, 4'd8, 1'b0}, // R3 ack -> 8
        {8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 4'd3, 1'b0}, // R5 restore 3
        {8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 1'b0}, // R5 restore 0
        {8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 1'b1}, // R6 empty pop
        {8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1}  // R6 sticky
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive at negedge, check combinational outputs, then registered ones
    task automatic step(input logic [7:0] r, input logic a, input logic t,
                        input logic e_irq, input logic [2:0] e_vec,
                        input logic [3:0] e_prio, input logic e_err,
                        input string tag);
        req_lines = r; ack = a; ret = t;
        #1;
        check({tag, " irq"}, int'(irq), int'(e_irq));
        if (e_irq) check({tag, " vector"}, int'(vector), int'(e_vec));
        @(posedge clk);
        @(negedge clk);
        check({tag, " cur_prio"}, int'(cur_prio), int'(e_prio));
        check({tag, " stack_err"}, int'(stack_err), int'(e_err));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_lines = 8'h02; ack = 1'b0; ret = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check("R8 cur_prio", int'(cur_prio), 0);
        check("R8 stack_err", int'(stack_err), 0);
        check("R8 irq", int'(irq), 1);
        check("R8 vector", int'(vector), 1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(TBL[i][18:11], TBL[i][10], TBL[i][9], TBL[i][8],
                 TBL[i][7:5], TBL[i][4:1], TBL[i][0], $sformatf("vec%0d", i));
        end

        // R8: reset clears the sticky flag again
        rst_n = 1'b0; req_lines = 8'h00; ack = 1'b0; ret = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        check("R8 err cleared", int'(stack_err), 0);
        check("R8 prio cleared", int'(cur_prio), 0);

        // R9: fill all eight levels
        for (int i = 0; i < 8; i++) begin
            step(8'(1 << i), 1'b1, 1'b0, 1'b1, 3'(i), 4'(i + 1), 1'b0, "R9 nest");
        end
        // R9: no request can outrank priority 8
        step(8'hFF, 1'b1, 1'b0, 1'b0, 3'd0, 4'd8, 1'b0, "R9 full no irq");
        // R9 / R5: unwind in reverse order
        for (int i = 7; i >= 0; i--) begin
            step(8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 4'(i), 1'b0, "R9 unwind");
        end
        // R6: one more return flags the error
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 1'b1, "R6 underflow");
        // R10: a line asserted then dropped leaves nothing behind
        step(8'h40, 1'b0, 1'b0, 1'b1, 3'd6, 4'd0, 1'b1, "R10 raised");
        step(8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R10 dropped");

        req_lines = 8'h00; ack = 1'b0; ret = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule